// File: doc/BRIEF.md
# Two-Wire Serial Register Target

This block is the target side of a two-wire serial bus (I2C) in front of a sixteen-entry byte register file. It oversamples the bus clock and data lines in the system clock domain and recognises bus start, repeated start and stop conditions. It accepts only transfers that carry its fixed seven-bit address. A write transfer first sets an internal register pointer and then stores bytes at successive locations. A read transfer returns bytes from successive locations, starting at the pointer. A random read is built from a write that sets the pointer, followed by a repeated start with the read direction.

The data line is handled in open-drain style. The block never drives a high level. It asserts `sda_pull` to pull the line low, and the surrounding pad logic turns that into an output enable. The register file sits outside the block. Each stored byte appears as a single-cycle write strobe with an address and data. Reads are served through a read address that always equals the pointer, with the byte returned combinationally. The system clock must run at least ten times faster than the bus clock.

Top module: `serial_reg_target`

## Requirements
- R1: The block responds only to the address byte whose upper seven bits are 1101000; the least significant bit of that byte selects the direction, 1 for a read and 0 for a write.
- R2: A falling data line while the clock is high is a start condition, and a repeated start is treated exactly like a start: it restarts address reception from any phase. A rising data line while the clock is high is a stop condition; it returns the block to idle and discards a partly received byte without a write strobe.
- R3: After a matching address byte, and after every byte received in a write transfer, `sda_pull` is high for the whole ninth (acknowledge) clock.
- R4: After a non-matching address the block gives no acknowledge, leaves `sda_pull` low, and issues no write strobe until the next start.
- R5: In a write transfer the first byte after the address loads its low four bits into the register pointer. Each later byte, received most significant bit first, produces exactly one `wr_en` pulse with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R6: The pointer advances by one during the acknowledge clock of each stored byte and of each read byte that the controller acknowledges, and wraps from 0Fh to 00h.
- R7: In a read transfer the block sends the byte at `rd_addr` most significant bit first, with `sda_pull` high exactly for 0 bits, and continues at the next location for as long as the controller acknowledges.
- R8: When the controller does not acknowledge a read byte, the block releases the data line and drives nothing until the next start, and the pointer does not advance.
- R9: `sda_pull` changes only while the bus clock is low.
- R10: After reset `sda_pull` and `wr_en` are low and the pointer is 00h, so a read issued without first setting the pointer returns location 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| wr_en | output | 1 | Single-cycle write strobe to the register file |
| wr_addr | output | 4 | Register address for the write strobe |
| wr_data | output | 8 | Byte to store |
| rd_addr | output | 4 | Register address to read; equals the pointer |
| rd_data | input | 8 | Byte held at `rd_addr`, returned combinationally |

## Verification
The hardest situations to reach from the ports are those where the pointer must not move, or a byte must not be stored. These include a stop that cuts a data byte in half, clocks that keep arriving after the controller declined a read byte, and traffic that follows a foreign address. The bench drives these sequences bit by bit from its own bus-controller tasks. It then probes the results only through normal transfers: it reads back the affected locations, counts write strobes, and issues a fresh read that shows where the pointer stands. Wrap-around is reached by aiming a multi-byte write and a multi-byte read at location 0Eh, so that both cross from 0Fh into 00h.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    // Transaction phase of the target
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_PTR,
        PH_PTR_ACK,
        PH_WBYTE,
        PH_WBYTE_ACK,
        PH_RBYTE,
        PH_RBYTE_ACK
    } phase_t;

    // Synchronised bus levels and the events derived from them
    typedef struct packed {
        logic clk_lvl;
        logic dat_lvl;
        logic clk_rise;
        logic clk_fall;
        logic begin_cond;
        logic end_cond;
    } bus_view_t;

    function automatic logic addr_hit(input byte_t b, input logic [6:0] own);
        return b[BYTE_W-1:1] == own;
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync
    import sreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_in,
    input  logic      sda_in,
    output bus_view_t view
);

    logic [STAGES-1:0] clk_q;
    logic [STAGES-1:0] dat_q;
    logic              clk_prev;
    logic              dat_prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        clk_q[0] <= 1'b1;
                        dat_q[0] <= 1'b1;
                    end else begin
                        clk_q[0] <= scl_in;
                        dat_q[0] <= sda_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        clk_q[s] <= 1'b1;
                        dat_q[s] <= 1'b1;
                    end else begin
                        clk_q[s] <= clk_q[s-1];
                        dat_q[s] <= dat_q[s-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev <= 1'b1;
            dat_prev <= 1'b1;
        end else begin
            clk_prev <= clk_q[STAGES-1];
            dat_prev <= dat_q[STAGES-1];
        end
    end

    always_comb begin
        view.clk_lvl    = clk_q[STAGES-1];
        view.dat_lvl    = dat_q[STAGES-1];
        view.clk_rise   = clk_q[STAGES-1] & ~clk_prev;
        view.clk_fall   = ~clk_q[STAGES-1] & clk_prev;
        view.begin_cond = clk_q[STAGES-1] & clk_prev & dat_prev & ~dat_q[STAGES-1];
        view.end_cond   = clk_q[STAGES-1] & clk_prev & ~dat_prev & dat_q[STAGES-1];
    end

    AST_COND_NEEDS_HIGH_CLK: assert property (@(posedge clk) disable iff (rst)
        (view.begin_cond || view.end_cond) |-> $past(view.clk_lvl)) // R2
        else $error("start/stop seen with clock low");

endmodule

// File: rtl/sreg_ptr.sv
module sreg_ptr #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> ptr == $past(ptr) + 1'b1) // R6
        else $error("pointer did not advance by one");

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr == '1) |=> ptr == '0) // R6
        else $error("pointer did not wrap to zero");

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr == $past(load_val)) // R5
        else $error("pointer load lost");

endmodule

// File: rtl/sreg_fsm.sv
module sreg_fsm
    import sreg_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'b1101000,
    parameter int         PTR_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_view_t        view,
    input  logic [PTR_W-1:0] ptr,
    input  byte_t            rd_data,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output byte_t            wr_data,
    output logic             ptr_load,
    output logic [PTR_W-1:0] ptr_load_val,
    output logic             ptr_step
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    phase_t           phase;
    byte_t            shreg;
    logic [CNT_W-1:0] bitcnt;
    logic             dir_read;
    logic             ctrl_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            shreg        <= '0;
            bitcnt       <= '0;
            dir_read     <= 1'b0;
            ctrl_ack     <= 1'b0;
            sda_pull     <= 1'b0;
            wr_en        <= 1'b0;
            wr_addr      <= '0;
            wr_data      <= '0;
            ptr_load     <= 1'b0;
            ptr_load_val <= '0;
            ptr_step     <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            ptr_load <= 1'b0;
            ptr_step <= 1'b0;
            if (view.begin_cond) begin
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (view.end_cond) begin
                phase    <= PH_IDLE;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (phase)
                    PH_IDLE: begin
                        sda_pull <= 1'b0;
                    end
                    PH_ADDR, PH_PTR, PH_WBYTE: begin
                        if (view.clk_rise && bitcnt != FULL_CNT) begin
                            shreg  <= {shreg[BYTE_W-2:0], view.dat_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (view.clk_fall && bitcnt == FULL_CNT) begin
                            bitcnt <= '0;
                            if (phase == PH_ADDR) begin
                                if (addr_hit(shreg, OWN_ADDR)) begin
                                    dir_read <= shreg[0];
                                    sda_pull <= 1'b1;
                                    phase    <= PH_ADDR_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else if (phase == PH_PTR) begin
                                ptr_load     <= 1'b1;
                                ptr_load_val <= shreg[PTR_W-1:0];
                                sda_pull     <= 1'b1;
                                phase        <= PH_PTR_ACK;
                            end else begin
                                wr_en    <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= shreg;
                                sda_pull <= 1'b1;
                                phase    <= PH_WBYTE_ACK;
                            end
                        end
                    end
                    PH_ADDR_ACK: begin
                        if (view.clk_fall) begin
                            bitcnt <= '0;
                            if (dir_read) begin
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                phase    <= PH_RBYTE;
                            end else begin
                                sda_pull <= 1'b0;
                                phase    <= PH_PTR;
                            end
                        end
                    end
                    PH_PTR_ACK: begin
                        if (view.clk_fall) begin
                            sda_pull <= 1'b0;
                            phase    <= PH_WBYTE;
                        end
                    end
                    PH_WBYTE_ACK: begin
                        if (view.clk_rise) begin
                            ptr_step <= 1'b1;
                        end
                        if (view.clk_fall) begin
                            sda_pull <= 1'b0;
                            phase    <= PH_WBYTE;
                        end
                    end
                    PH_RBYTE: begin
                        if (view.clk_fall) begin
                            if (bitcnt == LAST_TX) begin
                                sda_pull <= 1'b0;
                                phase    <= PH_RBYTE_ACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    PH_RBYTE_ACK: begin
                        if (view.clk_rise) begin
                            ctrl_ack <= ~view.dat_lvl;
                            ptr_step <= ~view.dat_lvl;
                        end
                        if (view.clk_fall) begin
                            bitcnt <= '0;
                            if (ctrl_ack) begin
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                phase    <= PH_RBYTE;
                            end else begin
                                sda_pull <= 1'b0;
                                phase    <= PH_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                        phase    <= PH_IDLE;
                    end
                endcase
            end
        end
    end

    AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (rst)
        view.begin_cond |=> (phase == PH_ADDR && !sda_pull)) // R2
        else $error("start did not restart address reception");

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_ADDR_ACK || phase == PH_PTR_ACK || phase == PH_WBYTE_ACK)
         && view.clk_lvl) |-> sda_pull) // R3
        else $error("acknowledge not held during high clock");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!sda_pull && !wr_en)) // R4
        else $error("activity while idle");

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en) // R5
        else $error("write strobe longer than one cycle");

    AST_NACK_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RBYTE_ACK && view.clk_rise && view.dat_lvl) |=> !ptr_step) // R8
        else $error("pointer stepped on controller NACK");

    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> !view.clk_lvl) // R9
        else $error("data line changed while clock high");

endmodule

// File: rtl/serial_reg_target.sv
module serial_reg_target
    import sreg_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'b1101000,
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] rd_addr,
    input  logic [7:0]       rd_data
);

    bus_view_t        view;
    logic [PTR_W-1:0] ptr;
    logic             ptr_load;
    logic [PTR_W-1:0] ptr_load_val;
    logic             ptr_step;

    sreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .view   (view)
    );

    sreg_fsm #(.OWN_ADDR(OWN_ADDR), .PTR_W(PTR_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .view         (view),
        .ptr          (ptr),
        .rd_data      (rd_data),
        .sda_pull     (sda_pull),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_step     (ptr_step)
    );

    sreg_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .step     (ptr_step),
        .ptr      (ptr)
    );

    assign rd_addr = ptr;

endmodule

// File: tb/sim_serial_reg_target.sv
module sim_serial_reg_target;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10 * CLK_PERIOD;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       bus_sda;

    logic [7:0] rf [16];
    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int r9_viol = 0;
    int cycles = 0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_sda = sda_m & ~sda_pull;
    assign rd_data = rf[rd_addr];

    serial_reg_target u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(bus_sda),
        .sda_pull(sda_pull), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Bench-side register file
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) rf[i] <= 8'(8'h90 + i);
        end else if (wr_en) begin
            rf[wr_addr] <= wr_data;
            wr_count <= wr_count + 1;
        end
    end

    // R9 monitor: data-line drive changes while bus clock high
    always @(negedge clk) begin
        if (!rst && sda_pull !== oe_prev && scl) r9_viol++;
        oe_prev = sda_pull;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #(Q);
        scl = 1'b1;   #(Q);
        sda_m = 1'b0; #(Q);
        scl = 1'b0;   #(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #(Q);
        scl = 1'b1;   #(Q);
        sda_m = 1'b1; #(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; #(Q);
        scl = 1'b1; #(2*Q);
        scl = 1'b0; #(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; #(Q);
        scl = 1'b1; #(Q);
        ack = ~bus_sda;
        #(Q);
        scl = 1'b0; #(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; #(Q);
            scl = 1'b1; #(Q);
            d[i] = bus_sda;
            #(Q);
            scl = 1'b0; #(Q);
        end
        sda_m = ~give_ack; #(Q);
        scl = 1'b1; #(2*Q);
        scl = 1'b0; #(Q);
    endtask

    task automatic t_reset();
        chk(sda_pull == 1'b0, "R10 sda_pull after reset", sda_pull, 0);
        chk(wr_en == 1'b0, "R10 wr_en after reset", wr_en, 0);
        chk(rd_addr == 4'h0, "R10 pointer after reset", rd_addr, 0);
    endtask

    task automatic t_read_after_reset();
        logic a; logic [7:0] d;
        bus_start();
        send_byte({7'b1101000, 1'b1}, a);
        chk(a, "R1 read address acknowledged", a, 1);
        recv_byte(1'b0, d);
        chk(d == 8'h90, "R10 first read returns location 00h", d, 8'h90);
        bus_stop();
    endtask

    task automatic t_write_single();
        logic a; logic [7:0] d; int c0;
        c0 = wr_count;
        bus_start();
        send_byte({7'b1101000, 1'b0}, a);
        chk(a, "R3 write address acknowledged", a, 1);
        send_byte(8'hF5, a);
        chk(a, "R3 pointer byte acknowledged", a, 1);
        send_byte(8'hA5, a);
        chk(a, "R3 data byte acknowledged", a, 1);
        bus_stop();
        chk(rf[5] == 8'hA5, "R5 byte stored at loaded pointer", rf[5], 8'hA5);
        chk(wr_count == c0 + 1, "R5 exactly one write strobe", wr_count - c0, 1);
        bus_start();
        send_byte({7'b1101000, 1'b1}, a);
        recv_byte(1'b0, d);
        chk(d == 8'h96, "R6 pointer advanced after write", d, 8'h96);
        bus_stop();
    endtask

    task automatic t_page_wrap();
        logic a;
        bus_start();
        send_byte({7'b1101000, 1'b0}, a);
        send_byte(8'h0E, a);
        send_byte(8'h3C, a);
        send_byte(8'hC3, a);
        send_byte(8'h5A, a);
        chk(a, "R3 last page byte acknowledged", a, 1);
        bus_stop();
        chk(rf[14] == 8'h3C, "R6 page write 0Eh", rf[14], 8'h3C);
        chk(rf[15] == 8'hC3, "R6 page write 0Fh", rf[15], 8'hC3);
        chk(rf[0] == 8'h5A, "R6 page write wraps to 00h", rf[0], 8'h5A);
    endtask

    task automatic t_random_read();
        logic a; logic [7:0] d;
        bus_start();
        send_byte({7'b1101000, 1'b0}, a);
        send_byte(8'h0E, a);
        bus_start();
        send_byte({7'b1101000, 1'b1}, a);
        chk(a, "R2 repeated start then read address acknowledged", a, 1);
        recv_byte(1'b1, d);
        chk(d == 8'h3C, "R7 read 0Eh", d, 8'h3C);
        recv_byte(1'b1, d);
        chk(d == 8'hC3, "R7 read 0Fh", d, 8'hC3);
        recv_byte(1'b0, d);
        chk(d == 8'h5A, "R6 read wraps to 00h", d, 8'h5A);
        chk(sda_pull == 1'b0, "R8 line released after NACK", sda_pull, 0);
        recv_byte(1'b1, d);
        chk(d == 8'hFF, "R8 no drive after NACK", d, 8'hFF);
        bus_stop();
        bus_start();
        send_byte({7'b1101000, 1'b1}, a);
        recv_byte(1'b0, d);
        chk(d == 8'h5A, "R8 pointer held after NACK", d, 8'h5A);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a; logic [7:0] d; int c0;
        c0 = wr_count;
        bus_start();
        send_byte({7'b1101001, 1'b0}, a);
        chk(!a, "R4 foreign address not acknowledged", a, 0);
        send_byte(8'h07, a);
        chk(!a, "R4 byte after foreign address not acknowledged", a, 0);
        send_byte(8'h11, a);
        bus_stop();
        chk(wr_count == c0, "R4 no write after foreign address", wr_count - c0, 0);
        chk(rf[7] == 8'h97, "R4 location untouched", rf[7], 8'h97);
        bus_start();
        send_byte({7'b0101000, 1'b1}, a);
        chk(!a, "R1 one-bit address difference rejected", a, 0);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R4 no read drive for foreign address", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_stop_abort();
        logic a; logic [7:0] d; int c0;
        c0 = wr_count;
        bus_start();
        send_byte({7'b1101000, 1'b0}, a);
        send_byte(8'h03, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        chk(wr_count == c0, "R2 stop discards partial byte", wr_count - c0, 0);
        chk(rf[3] == 8'h93, "R2 location untouched by partial byte", rf[3], 8'h93);
        bus_start();
        send_byte({7'b1101000, 1'b1}, a);
        recv_byte(1'b0, d);
        chk(d == 8'h93, "R2 pointer loaded before stop stays", d, 8'h93);
        bus_stop();
    endtask

    initial begin
        #(3*CLK_PERIOD + CLK_PERIOD/2);
        rst = 1'b0;
        #(2*CLK_PERIOD);
        t_reset();
        t_read_after_reset();
        t_write_single();
        t_page_wrap();
        t_random_read();
        t_mismatch();
        t_stop_abort();
        chk(r9_viol == 0, "R9 drive changed with clock high", r9_viol, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule